// File: doc/BRIEF.md
# Block Transfer Engine with Memory Bus Mastering

This block copies a run of words between main memory and one attached device with no processor work per word. Software sets a start address, a word count and a control word through a small register port. The engine then walks the block one word at a time. It requests the memory bus for each word, steps the address after every granted access, and counts the remaining words down to zero.

Two bus policies are offered. In cycle-stealing mode the bus is requested only for the single access of each word and is released in between. In burst mode a lock output is held for the whole block, so no other master can take the bus until the last word has moved. At the end the engine sets a completion flag. If interrupts are enabled it also raises an interrupt line, which stays high until software touches the control word.

Top module: `blk_dma`

## Requirements
- R1: After reset the address and count registers read 0. The control word reads 0x0000_0002 (complete flag set). `irq` is low and no memory or device handshake is active.
- R2: Registers are selected by `reg_sel`: 0 = address, 1 = count, 2 = control, 3 reads 0. Control bits:
  - bit 31 = interrupt pending (read-only)
  - bit 30 = interrupt enable
  - bit 3 = start (write-only, reads 0)
  - bit 2 = burst mode
  - bit 1 = complete (read-only)
  - bit 0 = direction
  - all other bits read 0.
- R3: While idle, either a count write or a control write with bit 3 set starts a block. Starting clears the complete flag and the interrupt-pending flag.
- R4: With direction = 1, each word is read from memory (`mem_we` = 0) and then offered on `dev_out_data`, in address order.
- R5: With direction = 0, each word accepted from `dev_in_data` is written to memory (`mem_we` = 1) at successive addresses.
- R6: The memory address advances by exactly one on each granted cycle and at no other time. An ungranted request holds its address and direction.
- R7: The count register decrements once per completed word and reads the number of words still to move. It reads 0 at completion.
- R8: When the last word completes, the complete flag is set. If interrupt enable is 1, the interrupt-pending flag and `irq` go high in the same cycle; otherwise they stay low.
- R9: `irq` stays high until a read or a write of the control word clears it.
- R10: Starting with a count of 0 completes on the start edge, with no memory request.
- R11: In cycle-stealing mode `mem_lock` stays low. In burst mode `mem_lock` is high from the cycle after the start until completion.
- R12: Register writes are ignored while a block is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending interrupt on control word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_sel` |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory grant; access completes on a cycle with req and gnt |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_lock | output | 1 | Bus held for the whole block (burst mode) |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid on the granted cycle |
| dev_out_valid | output | 1 | Word offered to device |
| dev_out_ready | input | 1 | Device accepts offered word |
| dev_out_data | output | DW | Word to device |
| dev_in_valid | input | 1 | Device presents a word |
| dev_in_ready | output | 1 | Engine accepts device word |
| dev_in_data | input | DW | Word from device |
| irq | output | 1 | Completion interrupt |

## Verification
Every cycle, the assertions check the following:
- a stalled request keeps its address and direction;
- the address moves by one per grant and is otherwise frozen while busy;
- the direction of each memory access matches the programmed direction;
- at most one handshake is open at a time;
- the lock follows the mode;
- `irq` implies completion and drops after a control read.

Only the bench scenarios can show the rest: that the right data lands at the right place in both directions under random stalls, that the count readback tracks words in flight, that busy writes leave the address untouched, and that a zero-length start completes at once.

// File: rtl/blk_dma.sv
module blk_dma #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          dev_out_valid,
  input  logic          dev_out_ready,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_in_valid,
  output logic          dev_in_ready,
  input  logic [DW-1:0] dev_in_data,
  output logic          irq
);
  localparam int B_RW    = 0;
  localparam int B_DONE  = 1;
  localparam int B_BURST = 2;
  localparam int B_GO    = 3;
  localparam int B_IE    = 30;
  localparam int B_IRQ   = 31;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_PUSH, S_PULL, S_STORE} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] buf_q;
  logic          rw_q, ie_q, burst_q, done_q, irq_q;

  logic          idle, wr_addr, wr_cnt, wr_ctrl, ctrl_touch, go;
  logic [CW-1:0] cnt_go;
  logic          rw_go, ie_go, word_end, last;

  assign idle       = (st == S_IDLE);
  assign wr_addr    = idle && reg_wr && reg_sel == 2'd0;
  assign wr_cnt     = idle && reg_wr && reg_sel == 2'd1;
  assign wr_ctrl    = idle && reg_wr && reg_sel == 2'd2;
  assign ctrl_touch = reg_sel == 2'd2 && (reg_wr || reg_rd);
  assign go         = wr_cnt || (wr_ctrl && reg_wdata[B_GO]);
  assign cnt_go     = wr_cnt  ? reg_wdata[CW-1:0] : cnt_q;
  assign rw_go      = wr_ctrl ? reg_wdata[B_RW]   : rw_q;
  assign ie_go      = wr_ctrl ? reg_wdata[B_IE]   : ie_q;
  assign word_end   = (st == S_PUSH && dev_out_ready) || (st == S_STORE && mem_gnt);
  assign last       = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      buf_q   <= '0;
      rw_q    <= 1'b0;
      ie_q    <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_touch) irq_q <= 1'b0;
      if (wr_addr) addr_q <= reg_wdata[AW-1:0];
      if (wr_ctrl) begin
        rw_q    <= reg_wdata[B_RW];
        ie_q    <= reg_wdata[B_IE];
        burst_q <= reg_wdata[B_BURST];
      end
      if (go) begin
        cnt_q <= cnt_go;
        if (cnt_go == '0) begin
          done_q <= 1'b1;
          irq_q  <= ie_go;
        end else begin
          done_q <= 1'b0;
          irq_q  <= 1'b0;
          st     <= rw_go ? S_FETCH : S_PULL;
        end
      end
      case (st)
        S_FETCH: if (mem_gnt) begin
          buf_q  <= mem_rdata;
          addr_q <= addr_q + AW'(1);
          st     <= S_PUSH;
        end
        S_PULL: if (dev_in_valid) begin
          buf_q <= dev_in_data;
          st    <= S_STORE;
        end
        S_STORE: if (mem_gnt) addr_q <= addr_q + AW'(1);
        default: ;
      endcase
      if (word_end) begin
        cnt_q <= cnt_q - CW'(1);
        if (last) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
          irq_q  <= ie_q;
        end else begin
          st <= rw_q ? S_FETCH : S_PULL;
        end
      end
    end
  end

  assign mem_req       = (st == S_FETCH) || (st == S_STORE);
  assign mem_we        = (st == S_STORE);
  assign mem_lock      = burst_q && !idle;
  assign mem_addr      = addr_q;
  assign mem_wdata     = buf_q;
  assign dev_out_valid = (st == S_PUSH);
  assign dev_out_data  = buf_q;
  assign dev_in_ready  = (st == S_PULL);
  assign irq           = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: reg_rdata = 32'(addr_q);
      2'd1: reg_rdata = 32'(cnt_q);
      2'd2: begin
        reg_rdata[B_RW]    = rw_q;
        reg_rdata[B_DONE]  = done_q;
        reg_rdata[B_BURST] = burst_q;
        reg_rdata[B_IE]    = ie_q;
        reg_rdata[B_IRQ]   = irq_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/blk_dma_chk.sv
module blk_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    reg_sel,
  input logic          reg_rd,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic          mem_lock,
  input logic [AW-1:0] mem_addr,
  input logic          dev_out_valid,
  input logic          dev_in_ready,
  input logic          irq,
  input logic          done_q,
  input logic          rw_q,
  input logic          burst_q
);
  p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> mem_addr == $past(mem_addr) + AW'(1));
  p_addr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q && !(mem_req && mem_gnt) |=> $stable(mem_addr));
  p_dir_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_we == !rw_q);
  p_one_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req, dev_out_valid, dev_in_ready}));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !mem_req && !dev_out_valid && !dev_in_ready);
  p_irq_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q);
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq && reg_rd && reg_sel == 2'd2 |=> !irq);
  p_steal_nolock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_q |-> !mem_lock);
  p_burst_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    burst_q && !done_q |-> mem_lock);
endmodule

bind blk_dma blk_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
  .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_lock(mem_lock),
  .mem_addr(mem_addr), .dev_out_valid(dev_out_valid), .dev_in_ready(dev_in_ready),
  .irq(irq), .done_q(done_q), .rw_q(rw_q), .burst_q(burst_q)
);

// File: tb/blk_dma_test.sv
module blk_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_gnt = 1'b0, mem_we, mem_lock;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        dev_out_valid, dev_out_ready = 1'b0;
  logic [31:0] dev_out_data;
  logic        dev_in_valid = 1'b0, dev_in_ready;
  logic [31:0] dev_in_data = '0;
  logic        irq;

  int vectors = 0, fails = 0, cyc = 0;
  logic [31:0] mem_m [0:255];
  logic [31:0] exp_w [0:31];
  logic        saw_req;

  always #5 clk = ~clk;

  blk_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data), .dev_in_valid(dev_in_valid), .dev_in_ready(dev_in_ready),
    .dev_in_data(dev_in_data), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) saw_req <= 1'b1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL R8 watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [31:0] ctrl_word(input logic irqb, input logic ie,
                                            input logic burst, input logic done, input logic rw);
    return {irqb, ie, 27'd0, burst, done, rw};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic run_block(input int base, input int n, input logic rw,
                           input logic burst, input logic ie, input logic disturb);
    int k = 0, kf = 0, pi = 0, it = 0;
    logic lock_bad = 1'b0, cnt_bad = 1'b0, addr_bad = 1'b0;
    logic hs_mem, hs_out, hs_in, was_dist;
    logic [31:0] r;
    for (int i = 0; i < n; i++) begin
      mem_m[(base + i) & 255] = $urandom;
      exp_w[i] = $urandom;
    end
    wr(2'd0, base);
    wr(2'd2, ctrl_word(1'b0, ie, burst, 1'b0, rw));
    wr(2'd1, n);
    while (k < n && it < 2000) begin
      @(negedge clk);
      it++;
      was_dist = disturb && it == 3;
      reg_wr = was_dist; reg_sel = was_dist ? 2'd0 : 2'd1; reg_wdata = 32'hDEAD;
      mem_gnt = ($urandom % 3) != 0;
      dev_out_ready = ($urandom % 2) != 0;
      dev_in_valid = !rw && (($urandom % 2) != 0);
      dev_in_data = exp_w[pi % 32];
      #1;
      if (mem_lock !== burst) lock_bad = 1'b1;
      if (!was_dist && reg_rdata !== 32'(n - k)) cnt_bad = 1'b1;
      hs_mem = mem_req && mem_gnt;
      hs_out = dev_out_valid && dev_out_ready;
      hs_in  = dev_in_valid && dev_in_ready;
      if (hs_mem && !mem_we) begin
        if (mem_addr !== 32'(base + kf)) addr_bad = 1'b1;
        mem_rdata = mem_m[mem_addr[7:0]];
      end
      if (hs_mem && mem_we) begin
        if (mem_addr !== 32'(base + k)) addr_bad = 1'b1;
        chk("R5 word stored", mem_wdata, exp_w[k]);
        mem_m[mem_addr[7:0]] = mem_wdata;
      end
      if (hs_out) chk("R4 word delivered", dev_out_data, mem_m[(base + k) & 255]);
      @(posedge clk);
      if (hs_mem && !mem_we) kf++;
      if (hs_mem && mem_we) k++;
      if (hs_out) k++;
      if (hs_in) pi++;
    end
    @(negedge clk);
    reg_wr = 1'b0; mem_gnt = 1'b0; dev_out_ready = 1'b0; dev_in_valid = 1'b0;
    if (it >= 2000) chk("R8 block finished", 32'(k), 32'(n));
    chk("R11 lock matches mode", {31'd0, lock_bad}, 32'd0);
    chk("R11 lock released", {31'd0, mem_lock}, 32'd0);
    chk("R7 count readback during block", {31'd0, cnt_bad}, 32'd0);
    chk("R6 address sequence", {31'd0, addr_bad}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R8 irq at completion", {31'd0, irq}, {31'd0, ie});
    rd(2'd2, r);
    chk("R8 control word after block", r, ctrl_word(ie, ie, burst, 1'b1, rw));
    chk("R9 irq cleared by control read", {31'd0, irq}, 32'd0);
    rd(2'd0, r);
    chk("R12 address after block", r, 32'(base + n));
    rd(2'd1, r);
    chk("R7 count zero at end", r, 32'd0);
  endtask

  initial begin
    logic [31:0] r;
    void'($urandom(32'd1977));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    chk("R1 no request", {29'd0, mem_req, dev_out_valid, dev_in_ready}, 32'd0);
    rd(2'd0, r); chk("R1 address reset", r, 32'd0);
    rd(2'd1, r); chk("R1 count reset", r, 32'd0);
    rd(2'd2, r); chk("R1 control reset", r, 32'h0000_0002);

    wr(2'd2, 32'hFFFF_FFF7);
    rd(2'd2, r); chk("R2 control layout", r, 32'h4000_0007);
    rd(2'd3, r); chk("R2 unused select", r, 32'd0);
    wr(2'd2, 32'd0);

    run_block(10, 1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_block(40, 5, 1'b0, 1'b1, 1'b1, 1'b1);
    run_block(80, 6, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int t = 0; t < 10; t++)
      run_block($urandom % 200, 1 + ($urandom % 20), 1'($urandom), 1'($urandom),
                1'($urandom), 1'b0);

    saw_req = 1'b0;
    wr(2'd2, 32'h4000_0008);
    @(negedge clk);
    chk("R10 zero count irq", {31'd0, irq}, 32'd1);
    rd(2'd1, r); chk("R10 count stays zero", r, 32'd0);
    chk("R10 no memory request", {31'd0, saw_req}, 32'd0);
    wr(2'd2, 32'h4000_0000);
    chk("R9 irq cleared by control write", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'd0);
    chk("R3 count write starts", {31'd0, irq}, 32'd1);
    rd(2'd2, r); chk("R3 control after restart", r, 32'hC000_0002);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule